// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access Checking

This block holds a small set of recently used virtual-to-physical page mappings and answers lookups against all of them at once. A request presents a virtual page number, whether the access is a write or a read, and whether the requester runs in user or kernel mode. In the same cycle the block reports one of three outcomes: a permitted hit that carries the physical page number, a miss, or a coded protection fault. An external page-table walker answers a miss by pushing a new mapping through the refill port.

Each slot stores a valid flag, read, write and user-access permissions, a dirty flag and a large-page flag, together with a virtual tag and a physical page number. A large-page slot compares only the upper part of the tag. The lower virtual bits then pass straight through into the physical page number. The victim slot for a refill comes from a round-robin pointer or from a free-running LFSR, chosen by a parameter. A flush input drops every mapping in one cycle.

Top module: `tlb_assoc`

## Requirements
- R1: A valid lookup that matches no valid slot raises `lk_miss` with `lk_hit` low and `lk_fault` = 0. After reset every lookup misses.
- R2: A matched lookup that passes the permission check raises `lk_hit` in the same cycle and drives the stored physical page number on `lk_ppn`.
- R3: A user-mode lookup (`lk_user`=1) that matches a slot whose user permission is clear gives `lk_fault` = 2'b01 and no hit. This outcome takes precedence over the read and write checks. Kernel mode never gets this fault.
- R4: If R3 does not apply, a write to a slot without write permission gives `lk_fault` = 2'b11, and a read from a slot without read permission gives `lk_fault` = 2'b10.
- R5: A large-page slot compares only `lk_vpn[19:10]`. On a hit, `lk_ppn` = {stored ppn[19:10], `lk_vpn[9:0]`}. A normal slot compares all 20 bits.
- R6: When several slots match, the slot with the lowest index supplies the result.
- R7: `lk_dirty` shows the dirty flag of the matched slot. A refill loads that flag from `rf_dirty`. A permitted write hit sets it at the next clock edge.
- R8: With `RANDOM_REPL`=0, refills fill slots 0, 1, 2, … in order and wrap from the last slot back to slot 0. Each refill evicts the previous occupant of its slot.
- R9: With `RANDOM_REPL`=1, a 16-bit LFSR that never holds zero picks the victim. A refilled mapping hits on the cycle after the refill.
- R10: `flush_all` invalidates every slot at one clock edge. A refill presented in the same cycle is discarded.
- R11: Every valid lookup produces exactly one of: a hit, a miss, or a nonzero fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Invalidate all slots |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number of the lookup |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_hit | output | 1 | Permitted hit |
| lk_miss | output | 1 | No valid slot matched |
| lk_fault | output | 2 | 00 none, 01 user denied, 10 read denied, 11 write denied |
| lk_ppn | output | PPN_W | Translated physical page number |
| lk_dirty | output | 1 | Dirty flag of the matched slot |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | VPN_W | Tag of the new mapping |
| rf_ppn | input | PPN_W | Physical page of the new mapping |
| rf_read | input | 1 | Read permission |
| rf_write | input | 1 | Write permission |
| rf_user | input | 1 | User-mode permission |
| rf_dirty | input | 1 | Initial dirty flag |
| rf_large | input | 1 | Large-page mapping |

## Verification
The bench loads eight slots that cover every combination of the three permissions. It then sweeps both modes and both access types over all of them. A wrong fault priority would show up as a read or write code where the user code belongs. It places a large mapping below an overlapping small one. A design that compared the full tag on large pages would miss, and one that took the highest matching index would return the small page's number. It also covers the FIFO wrap, the setting of the dirty flag by a write and the flush that swallows a simultaneous refill. Each of these shows up as a stale hit or a lost flag when it is wrong.

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
  parameter int ENTRIES     = 64,
  parameter int VPN_W       = 20,
  parameter int PPN_W       = 20,
  parameter int LG_BITS     = 10,
  parameter bit RANDOM_REPL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_all,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_write,
  input  logic             lk_user,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [1:0]       lk_fault,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_dirty,
  input  logic             rf_valid,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [PPN_W-1:0] rf_ppn,
  input  logic             rf_read,
  input  logic             rf_write,
  input  logic             rf_user,
  input  logic             rf_dirty,
  input  logic             rf_large
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [15:0] ENT16 = 16'(ENTRIES);

  logic [ENTRIES-1:0] e_v, e_r, e_w, e_u, e_d, e_l;
  logic [VPN_W-1:0]   e_tag [ENTRIES];
  logic [PPN_W-1:0]   e_ppn [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   sel, victim;
  logic               found, deny_u, deny_w, deny_r, accept_rf;

  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      match[i] = e_v[i] && (e_tag[i][VPN_W-1:LG_BITS] == lk_vpn[VPN_W-1:LG_BITS]) &&
                 (e_l[i] || e_tag[i][LG_BITS-1:0] == lk_vpn[LG_BITS-1:0]);
      if (match[i]) sel = IDX_W'(i);
    end
  end

  assign found  = lk_valid && (|match);
  assign deny_u = lk_user && !e_u[sel];
  assign deny_w = lk_write && !e_w[sel];
  assign deny_r = !lk_write && !e_r[sel];

  assign lk_fault = !found ? 2'b00 : deny_u ? 2'b01 : deny_w ? 2'b11 : deny_r ? 2'b10 : 2'b00;
  assign lk_hit   = found && !deny_u && !deny_w && !deny_r;
  assign lk_miss  = lk_valid && !(|match);
  assign lk_dirty = e_d[sel];
  assign lk_ppn   = e_l[sel] ? {e_ppn[sel][PPN_W-1:LG_BITS], lk_vpn[LG_BITS-1:0]} : e_ppn[sel];

  assign accept_rf = rf_valid && !flush_all;

  generate
    if (RANDOM_REPL) begin : g_rand
      logic [15:0] lfsr;
      always_ff @(posedge clk) begin
        if (!rst_n) lfsr <= 16'hACE1;
        else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end
      assign victim = IDX_W'(lfsr % ENT16);
      // R9
      lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n) lfsr != 16'h0);
    end else begin : g_fifo
      logic [IDX_W-1:0] ptr;
      always_ff @(posedge clk) begin
        if (!rst_n)         ptr <= '0;
        else if (accept_rf) ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
      end
      assign victim = ptr;
      // R8
      fifo_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_rf |=> victim == (($past(victim) == IDX_W'(ENTRIES - 1)) ? '0 : $past(victim) + 1'b1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_v <= '0; e_r <= '0; e_w <= '0; e_u <= '0; e_d <= '0; e_l <= '0;
    end else if (flush_all) begin
      e_v <= '0;
    end else begin
      if (lk_hit && lk_write) e_d[sel] <= 1'b1;
      if (rf_valid) begin
        e_v[victim] <= 1'b1;
        e_r[victim] <= rf_read;
        e_w[victim] <= rf_write;
        e_u[victim] <= rf_user;
        e_d[victim] <= rf_dirty;
        e_l[victim] <= rf_large;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept_rf) begin
      e_tag[victim] <= rf_vpn;
      e_ppn[victim] <= rf_ppn;
    end
  end

  // R11
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $countones({lk_hit, lk_miss, lk_fault != 2'b00}) == 1);
  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (!lk_valid || lk_miss));
  // R7
  dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_write && !flush_all && !rf_valid ##1 lk_valid && lk_vpn == $past(lk_vpn)) |-> lk_dirty);
  // R3
  user_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault == 2'b01 |-> lk_user);
endmodule

// File: tb/tlb_assoc_tb.sv
module tlb_assoc_tb;
  logic clk = 1'b0, rst_n = 1'b0, flush_all = 1'b0;
  logic lk_valid = 1'b0, lk_write = 1'b0, lk_user = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic rf_valid = 1'b0, rf_read = 1'b0, rf_write = 1'b0, rf_user = 1'b0, rf_dirty = 1'b0, rf_large = 1'b0;
  logic [19:0] rf_vpn = '0, rf_ppn = '0;
  logic hit, miss, dirty, hit_r, miss_r, dirty_r;
  logic [1:0] fault, fault_r;
  logic [19:0] ppn, ppn_r;
  int total = 0, bad = 0;
  logic [7:0] exp_d = '0;

  always #2 clk = ~clk;

  tlb_assoc #(.ENTRIES(8), .RANDOM_REPL(1'b0)) u_dut (
    .clk, .rst_n, .flush_all, .lk_valid, .lk_vpn, .lk_write, .lk_user,
    .lk_hit(hit), .lk_miss(miss), .lk_fault(fault), .lk_ppn(ppn), .lk_dirty(dirty),
    .rf_valid, .rf_vpn, .rf_ppn, .rf_read, .rf_write, .rf_user, .rf_dirty, .rf_large);

  tlb_assoc #(.ENTRIES(8), .RANDOM_REPL(1'b1)) u_dut_rnd (
    .clk, .rst_n, .flush_all, .lk_valid, .lk_vpn, .lk_write, .lk_user,
    .lk_hit(hit_r), .lk_miss(miss_r), .lk_fault(fault_r), .lk_ppn(ppn_r), .lk_dirty(dirty_r),
    .rf_valid, .rf_vpn, .rf_ppn, .rf_read, .rf_write, .rf_user, .rf_dirty, .rf_large);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic refill(logic [19:0] v, logic [19:0] p, logic r, logic w, logic u, logic d, logic l, logic fl);
    @(negedge clk);
    lk_valid = 1'b0; flush_all = fl;
    rf_valid = 1'b1; rf_vpn = v; rf_ppn = p;
    rf_read = r; rf_write = w; rf_user = u; rf_dirty = d; rf_large = l;
    @(negedge clk);
    rf_valid = 1'b0; flush_all = 1'b0;
  endtask

  task automatic look(logic [19:0] v, logic w, logic u);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v; lk_write = w; lk_user = u;
    #1;
  endtask

  // outcome word: {hit, miss, fault, ppn}
  function automatic logic [31:0] res();
    return {8'h0, hit, miss, fault, ppn};
  endfunction

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look(20'h10000, 1'b0, 1'b0);
    check("R1 reset miss", res() & 32'h00F00000, 32'h00400000);

    refill(20'h10000, 20'h0A000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    look(20'h10000, 1'b0, 1'b0);
    check("R9 random refill hittable", {hit_r | fault_r != 2'b00, miss_r}, 2'b10);
    for (int i = 1; i < 8; i++)
      refill(20'h10000 | 20'(i), 20'h0A000 + 20'(i * 3), i[0], i[1], i[2], 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < 4; k++) begin
        logic wr, us;
        logic [1:0] ef;
        logic [31:0] exp;
        wr = k[1]; us = k[0];
        ef = (us && !i[2]) ? 2'b01 : (wr && !i[1]) ? 2'b11 : (!wr && !i[0]) ? 2'b10 : 2'b00;
        look(20'h10000 | 20'(i), wr, us);
        if (ef == 2'b00) begin
          exp = {8'h0, 1'b1, 1'b0, 2'b00, 20'h0A000 + 20'(i * 3)};
          check("R2 permitted hit", res(), exp);
          check("R7 dirty before write", {31'h0, dirty}, {31'h0, exp_d[i]});
          if (wr) exp_d[i] = 1'b1;
        end else begin
          check(ef == 2'b01 ? "R3 user fault" : "R4 rw fault", res() & 32'h00F00000, {8'h0, 4'b00, ef, 20'h0});
        end
      end
      look(20'h10000 | 20'(i), 1'b0, 1'b0);
      check("R7 dirty after write", {31'h0, dirty}, {31'h0, exp_d[i]});
    end

    look(20'h12345, 1'b0, 1'b0);
    check("R1 unmatched miss", res() & 32'h00F00000, 32'h00400000);
    look(20'h10001, 1'b0, 1'b0);
    check("R11 single outcome", {29'h0, hit, miss, fault != 2'b00}, 32'h4);

    refill(20'h20000, 20'h0BBBB, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    look(20'h10000, 1'b0, 1'b0);
    check("R8 slot0 evicted", {31'h0, miss}, 32'h1);
    look(20'h20000, 1'b0, 1'b1);
    check("R8 new mapping", res(), {8'h0, 4'b1000, 20'h0BBBB});
    check("R7 refill dirty", {31'h0, dirty}, 32'h1);

    refill(20'h30000, 20'h55C00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    look(20'h10001, 1'b0, 1'b0);
    check("R8 slot1 evicted", {31'h0, miss}, 32'h1);
    look(20'h303A5, 1'b0, 1'b1);
    check("R5 large page", res(), {8'h0, 4'b1000, 20'h55FA5});
    look(20'h30400, 1'b0, 1'b0);
    check("R5 large outside", {31'h0, miss}, 32'h1);

    refill(20'h303A5, 20'h77777, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    look(20'h10002, 1'b0, 1'b0);
    check("R8 slot2 evicted", {31'h0, miss}, 32'h1);
    look(20'h10003, 1'b0, 1'b0);
    check("R8 slot3 kept", res(), {8'h0, 4'b1000, 20'h0A009});
    look(20'h303A5, 1'b1, 1'b1);
    check("R6 lowest index", res(), {8'h0, 4'b1000, 20'h55FA5});
    check("R7 large clean", {31'h0, dirty}, 32'h0);
    look(20'h303A5, 1'b0, 1'b0);
    check("R7 large dirty", {31'h0, dirty}, 32'h1);

    @(negedge clk);
    lk_valid = 1'b0; flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
    look(20'h20000, 1'b0, 1'b0);
    check("R10 flushed", {31'h0, miss}, 32'h1);
    look(20'h10003, 1'b0, 1'b0);
    check("R10 flushed", {31'h0, miss}, 32'h1);

    refill(20'h44444, 20'h12121, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    look(20'h44444, 1'b0, 1'b0);
    check("R10 refill dropped", {31'h0, miss}, 32'h1);
    refill(20'h44444, 20'h12121, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    look(20'h44444, 1'b0, 1'b0);
    check("R2 refill after flush", res(), {8'h0, 4'b1000, 20'h12121});

    @(negedge clk);
    lk_valid = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule